// File: doc/BRIEF.md
# Half-Duplex Transmit Collision and Partition Controller

This block is the per-port transmit arbiter of a 10/100 Mbit/s half-duplex Ethernet port. It decides when the client may start a frame. Before a grant, the carrier must have stayed quiet for the minimum inter-frame gap. After a collision the block jams the medium and then waits a randomly drawn number of slot times before it retries. A frame whose collision arrives after the first slot time is given up without retry. A frame that collides sixteen times is aborted.

The block also carries two functions that sit beside the transmit path. For flow control, it jams a partner that starts to send while backpressure is requested. It also guards against a faulty segment: when enabled, it stops reception after a long run of consecutive collisions, and it opens reception again once a frame goes through a full slot time cleanly.

Time is measured in bit times. `bit_tick` is a strobe at the 100 Mbit/s bit rate. At 10 Mbit/s, every tenth strobe counts as one bit time. The client holds `tx_req` while a frame is pending. It pulses `tx_end` on the last bit of a frame, and it withdraws `tx_req` when the frame ends, is aborted or is dropped.

Top module: `hdx_tx_ctrl`

## Requirements
- R1: A grant starts only after the carrier has been idle, and the port has neither transmitted nor jammed, for at least 96 bit times. One bit time is one `bit_tick` when `speed_100`=1 and ten ticks when `speed_100`=0.
- R2: `tx_grant` never rises while `crs` is high or `tx_req` is low. Once granted, it stays high until `tx_end` or a collision.
- R3: A collision before 512 bit times of the frame is followed by a jam and then a backoff of r slots of 512 bit times, where 0 <= r <= 2^min(n,BO_EXP_MAX)-1 for the nth collision. After the backoff the frame is granted again.
- R4: On the 16th collision of one frame, `tx_abort` pulses for one cycle as the jam ends, and the frame receives no further grant.
- R5: A collision at or after 512 bit times of the frame is followed by a jam and a one-cycle `tx_drop` pulse as the jam ends. There is no retry and no `tx_abort`.
- R6: While idle with `bp_req`=1, the port holds `jam` high for as long as `crs`=1, and drops `jam` when `crs` falls. With `bp_req`=0, carrier alone never raises `jam`.
- R7: Collisions are counted across frames. With `part_en`=1, `rx_en` falls when the count exceeds 64: it is still 1 after 64 collisions and 0 after 65.
- R8: While partitioned, the port is still granted. A frame that reaches 512 bit times without collision clears the count and sets `rx_en` to 1.
- R9: With `part_en`=0, `rx_en` is 1 whatever the collision count.
- R10: After reset, `tx_grant`, `jam`, `tx_abort` and `tx_drop` are 0 and `rx_en` is 1.
- R11: `jam` and `tx_grant` are never high together. A collision during a grant lowers the grant and raises `jam` on the next cycle.
- R12: Each collision jam lasts 32 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | Strobe at the 100 Mbit/s bit rate |
| speed_100 | input | 1 | 1: 100 Mbit/s, 0: 10 Mbit/s |
| tx_req | input | 1 | Frame pending, held by the client |
| tx_end | input | 1 | Pulse on the last bit of a granted frame |
| col | input | 1 | Collision indication from the line |
| crs | input | 1 | Carrier or receive activity |
| bp_req | input | 1 | Backpressure (flow control) request |
| part_en | input | 1 | Enables partition on excessive collisions |
| tx_grant | output | 1 | Client may transmit |
| tx_abort | output | 1 | Pulse: frame abandoned after 16 collisions |
| tx_drop | output | 1 | Pulse: frame dropped after a late collision |
| jam | output | 1 | Jam pattern to be sent |
| rx_en | output | 1 | Reception allowed |

## Verification
The assertions cover the properties that hold cycle by cycle:
- grant and jam are mutually exclusive;
- a collision during a grant hands over to the jam on the next cycle;
- a grant rises only from a quiet carrier with a pending request;
- abort and drop are single-cycle pulses and never coincide;
- reception closes only at a collision or when partition is enabled;
- reception stays open with partition disabled.

The quantities that need time and history are shown only by the bench scenarios:
- the length of the inter-frame gap at both speeds;
- the 32-bit jam length;
- the bound on the backoff delay;
- the boundary between an early and a late collision;
- the count of sixteen attempts before an abort;
- the 64/65 partition threshold and the release after a clean slot.

// File: rtl/hdx_pkg.sv
// Shared types of the half-duplex transmit controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hdx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a request and a quiet medium
        ST_TX,       // frame granted to the client
        ST_JAM,      // jamming after a collision
        ST_BACKOFF,  // waiting the drawn number of slots
        ST_BPJAM     // jamming the partner for flow control
    } tx_state_e;
endpackage

// File: rtl/hdx_bit_timer.sv
// Turns the base bit-rate strobe into a bit-time enable for the selected speed.
// Assumes: bit_tick is a one-cycle strobe at the fast bit rate. At the slow
// speed every SLOW_DIV-th strobe counts.
module hdx_bit_timer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic speed_100,
    output logic bit_en
);
    localparam int PRE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [PRE_W-1:0] pre;

    // Prescaler that counts strobes at the slow speed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (bit_tick && !speed_100) begin
            pre <= (pre == PRE_W'(SLOW_DIV - 1)) ? '0 : pre + 1'b1;
        end
    end

    // Bit-time enable: every strobe at full speed, the last of each group at slow speed.
    assign bit_en = bit_tick && (speed_100 || (pre == PRE_W'(SLOW_DIV - 1)));
endmodule

// File: rtl/hdx_ipg_timer.sv
// Measures the quiet time since the medium or the port was last busy.
// Assumes: busy covers carrier, own transmission and own jam.
module hdx_ipg_timer #(
    parameter int IPG_BITS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic busy,
    output logic ipg_ok
);
    localparam int IW = $clog2(IPG_BITS + 1);

    logic [IW-1:0] quiet;

    // Saturating count of quiet bit times, restarted by any activity.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            quiet <= '0;
        end else if (bit_en && quiet != IW'(IPG_BITS)) begin
            quiet <= quiet + 1'b1;
        end
    end

    assign ipg_ok = (quiet == IW'(IPG_BITS));
endmodule

// File: rtl/hdx_backoff_lfsr.sv
// Free-running Galois LFSR that supplies the random slot count for backoff.
// Assumes: SEED is non-zero and TAPS is a maximal-length polynomial of width LFSR_W.
module hdx_backoff_lfsr #(
    parameter int             LFSR_W = 16,
    parameter int             OUT_W  = 10,
    parameter logic [15:0]    TAPS   = 16'hB400,
    parameter logic [15:0]    SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [LFSR_W-1:0] sr;

    // Advance the register every cycle so that the draw depends on the exact collision time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= SEED[LFSR_W-1:0];
        end else if (sr[0]) begin
            sr <= (sr >> 1) ^ TAPS[LFSR_W-1:0];
        end else begin
            sr <= sr >> 1;
        end
    end

    assign rnd = sr[OUT_W-1:0];
endmodule

// File: rtl/hdx_coll_track.sv
// Counts consecutive collisions across frames and gates reception when partitioned.
// Assumes: col_hit and slot_clean are single-cycle events that never coincide.
module hdx_coll_track #(
    parameter int PART_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_hit,
    input  logic slot_clean,
    input  logic part_en,
    output logic rx_en
);
    localparam int CW = $clog2(PART_LIMIT + 2);

    logic [CW-1:0] consec;

    // Saturating count of collisions, cleared by a clean slot time.
    always_ff @(posedge clk) begin
        if (!rst_n || slot_clean) begin
            consec <= '0;
        end else if (col_hit && consec != CW'(PART_LIMIT + 1)) begin
            consec <= consec + 1'b1;
        end
    end

    // Reception is closed only while partition is enabled and the limit has been passed.
    assign rx_en = !(part_en && (consec > CW'(PART_LIMIT)));
endmodule

// File: rtl/hdx_tx_ctrl.sv
// Half-duplex transmit controller: gap timing, collision jam, backoff,
// late-collision drop, excessive-collision abort, backpressure jam and partition.
// Assumes: the client holds tx_req until tx_end, tx_abort or tx_drop, and
// JAM_BITS < SLOT_BITS.
module hdx_tx_ctrl #(
    parameter int SLOW_DIV     = 10,
    parameter int IPG_BITS     = 96,
    parameter int SLOT_BITS    = 512,
    parameter int JAM_BITS     = 32,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BO_EXP_MAX   = 10,
    parameter int PART_LIMIT   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic speed_100,
    input  logic tx_req,
    input  logic tx_end,
    input  logic col,
    input  logic crs,
    input  logic bp_req,
    input  logic part_en,
    output logic tx_grant,
    output logic tx_abort,
    output logic tx_drop,
    output logic jam,
    output logic rx_en
);
    import hdx_pkg::*;

    localparam int CNT_W = $clog2(SLOT_BITS + 1);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

    tx_state_e            state;
    logic [CNT_W-1:0]     tcnt;
    logic [BO_EXP_MAX-1:0] slots_left;
    logic [BO_EXP_MAX-1:0] rnd;
    logic [BO_EXP_MAX-1:0] draw_mask;
    logic [BO_EXP_MAX-1:0] draw;
    logic [ATT_W-1:0]     att;
    logic                 late;
    logic                 abort_q;
    logic                 drop_q;
    logic                 bit_en;
    logic                 ipg_ok;
    logic                 busy;
    logic                 col_hit;
    logic                 slot_clean;

    hdx_bit_timer #(.SLOW_DIV(SLOW_DIV)) u_bit (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .speed_100(speed_100), .bit_en(bit_en)
    );

    hdx_ipg_timer #(.IPG_BITS(IPG_BITS)) u_ipg (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .busy(busy), .ipg_ok(ipg_ok)
    );

    hdx_backoff_lfsr #(.OUT_W(BO_EXP_MAX)) u_rnd (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    hdx_coll_track #(.PART_LIMIT(PART_LIMIT)) u_part (
        .clk(clk), .rst_n(rst_n), .col_hit(col_hit), .slot_clean(slot_clean),
        .part_en(part_en), .rx_en(rx_en)
    );

    // Activity that restarts the gap: carrier, own frame or any jam.
    assign busy = crs || (state == ST_TX) || (state == ST_JAM) || (state == ST_BPJAM);

    // Collision events seen by the partition counter.
    assign col_hit    = (state == ST_TX) && col;
    assign slot_clean = (state == ST_TX) && !col && bit_en && (tcnt == CNT_W'(SLOT_BITS - 1));

    // Backoff range: bit i is open once the attempt count exceeds i, capped at BO_EXP_MAX bits.
    always_comb begin
        for (int i = 0; i < BO_EXP_MAX; i++) begin
            draw_mask[i] = (int'(att) > i);
        end
        draw = rnd & draw_mask;
    end

    // Main transmit state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            slots_left <= '0;
            att        <= '0;
            late       <= 1'b0;
            abort_q    <= 1'b0;
            drop_q     <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            drop_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (bp_req && crs) begin
                        state <= ST_BPJAM;
                    end else if (tx_req && !crs && ipg_ok) begin
                        state <= ST_TX;
                        tcnt  <= '0;
                    end
                end
                ST_TX: begin
                    if (col) begin
                        state <= ST_JAM;
                        late  <= (tcnt >= CNT_W'(SLOT_BITS));
                        tcnt  <= '0;
                        att   <= att + 1'b1;
                    end else if (tx_end) begin
                        state <= ST_IDLE;
                        att   <= '0;
                    end else if (bit_en && tcnt != CNT_W'(SLOT_BITS)) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_JAM: begin
                    if (bit_en) begin
                        if (tcnt == CNT_W'(JAM_BITS - 1)) begin
                            tcnt <= '0;
                            if (late) begin
                                drop_q <= 1'b1;
                                state  <= ST_IDLE;
                                att    <= '0;
                            end else if (att == ATT_W'(MAX_ATTEMPTS)) begin
                                abort_q <= 1'b1;
                                state   <= ST_IDLE;
                                att     <= '0;
                            end else if (draw == '0) begin
                                state <= ST_IDLE;
                            end else begin
                                state      <= ST_BACKOFF;
                                slots_left <= draw;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (bit_en) begin
                        if (tcnt == CNT_W'(SLOT_BITS - 1)) begin
                            tcnt <= '0;
                            if (slots_left == BO_EXP_MAX'(1)) begin
                                state <= ST_IDLE;
                            end
                            slots_left <= slots_left - 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_BPJAM: begin
                    if (!(bp_req && crs)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_grant = (state == ST_TX);
    assign jam      = (state == ST_JAM) || (state == ST_BPJAM);
    assign tx_abort = abort_q;
    assign tx_drop  = drop_q;
endmodule

// File: rtl/hdx_tx_ctrl_chk.sv
// Cycle-level properties of the transmit controller, bound to the top module.
// Assumes: the synchronous active-low reset of the design.
module hdx_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic col,
    input logic crs,
    input logic part_en,
    input logic tx_grant,
    input logic jam,
    input logic tx_abort,
    input logic tx_drop,
    input logic rx_en
);
    // R11: grant and jam never overlap.
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_grant && jam));

    // R11: a collision during a grant hands over to the jam.
    a_r11_col_to_jam: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && col) |=> (jam && !tx_grant));

    // R2: a grant starts only from a quiet carrier with a pending request.
    a_r2_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> $past(!crs && tx_req));

    // R4: abort is a single-cycle pulse.
    a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    // R5: drop is a single-cycle pulse and never coincides with abort.
    a_r5_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> !tx_drop);
    a_r5_not_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_drop && tx_abort));

    // R7: reception closes only at a collision or when partition is switched on.
    a_r7_rx_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en) |-> (jam || $past(!part_en)));

    // R9: with partition disabled, reception stays open.
    a_r9_rx_open: assert property (@(posedge clk) disable iff (!rst_n)
        !part_en |-> rx_en);
endmodule

bind hdx_tx_ctrl hdx_tx_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .col(col), .crs(crs),
    .part_en(part_en), .tx_grant(tx_grant), .jam(jam), .tx_abort(tx_abort),
    .tx_drop(tx_drop), .rx_en(rx_en)
);

// File: tb/sim_hdx_tx_ctrl.sv
module sim_hdx_tx_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic speed_100 = 1'b1;
    logic tx_req = 1'b0;
    logic tx_end = 1'b0;
    logic col = 1'b0;
    logic crs = 1'b0;
    logic bp_req = 1'b0;
    logic part_en = 1'b0;
    logic tx_grant, tx_abort, tx_drop, jam, rx_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct packed {
        logic [15:0] delay;
        logic        drop;
    } lc_vec_t;

    // Collision offset after grant and whether the frame must be dropped (R3 early, R5 late).
    localparam lc_vec_t VECS [5] = '{
        '{16'd20,  1'b0},
        '{16'd250, 1'b0},
        '{16'd480, 1'b0},
        '{16'd560, 1'b1},
        '{16'd800, 1'b1}
    };

    always #2.5 clk = ~clk;

    hdx_tx_ctrl #(.BO_EXP_MAX(1)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
        .tx_req(tx_req), .tx_end(tx_end), .col(col), .crs(crs), .bp_req(bp_req),
        .part_en(part_en), .tx_grant(tx_grant), .tx_abort(tx_abort),
        .tx_drop(tx_drop), .jam(jam), .rx_en(rx_en)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tx_req = 0; tx_end = 0; col = 0; crs = 0; bp_req = 0;
        rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Wait for a grant, returning the number of cycles waited (-1 on timeout).
    task automatic wait_grant(input int limit, output int n);
        n = 0;
        while (!tx_grant && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!tx_grant) n = -1;
    endtask

    // Collide after 'delay' cycles of grant and follow the jam to its end.
    task automatic collide(input int delay, output int jlen, output bit ab, output bit dr);
        repeat (delay) @(negedge clk);
        col = 1;
        @(negedge clk);
        col = 0;
        jlen = 0;
        while (jam && jlen < 2000) begin
            jlen++;
            @(negedge clk);
        end
        ab = tx_abort;
        dr = tx_drop;
    endtask

    initial begin
        int n, jl, ncol;
        bit ab, dr;

        // R10: reset state.
        do_reset();
        check(!tx_grant && !jam && !tx_abort && !tx_drop, "R10 outputs idle", int'(tx_grant | jam), 0);
        check(rx_en, "R10 rx_en", int'(rx_en), 1);

        // Table of early and late collisions.
        foreach (VECS[i]) begin
            do_reset();
            tx_req = 1;
            wait_grant(300, n);
            check(n >= 0, "R1 first grant", n, 96);
            collide(int'(VECS[i].delay), jl, ab, dr);
            check(jl >= 32 && jl <= 33, "R12 jam length", jl, 32);
            check(dr == VECS[i].drop, VECS[i].drop ? "R5 late drop" : "R3 no drop", int'(dr), int'(VECS[i].drop));
            check(!ab, "R5 no abort", int'(ab), 0);
            if (!VECS[i].drop) begin
                wait_grant(800, n);
                check(n >= 94 && n <= 512 + 110, "R3 backoff delay", n, 512);
            end else begin
                tx_req = 0;
                wait_grant(800, n);
                check(n < 0, "R5 no retry", n, -1);
            end
            if (tx_grant) begin
                tx_end = 1; @(negedge clk); tx_end = 0;
            end
            tx_req = 0;
        end

        // R1: gap after carrier at 100 Mbit/s.
        do_reset();
        crs = 1; tx_req = 1;
        repeat (50) @(negedge clk);
        check(!tx_grant, "R2 defer on carrier", int'(tx_grant), 0);
        crs = 0;
        wait_grant(3000, n);
        check(n >= 96 && n <= 100, "R1 gap 100M", n, 96);
        tx_end = 1; @(negedge clk); tx_end = 0; tx_req = 0;

        // R1: gap after carrier at 10 Mbit/s.
        do_reset();
        speed_100 = 0;
        crs = 1; tx_req = 1;
        repeat (30) @(negedge clk);
        crs = 0;
        wait_grant(3000, n);
        check(n >= 960 && n <= 975, "R1 gap 10M", n, 960);
        repeat (40) @(negedge clk);
        check(tx_grant, "R2 grant held", int'(tx_grant), 1);
        tx_end = 1; @(negedge clk); tx_end = 0; tx_req = 0;
        speed_100 = 1;

        // R6: backpressure jam.
        do_reset();
        crs = 1;
        repeat (5) @(negedge clk);
        check(!jam, "R6 no jam without request", int'(jam), 0);
        bp_req = 1;
        repeat (3) @(negedge clk);
        check(jam, "R6 jam on carrier", int'(jam), 1);
        crs = 0;
        repeat (2) @(negedge clk);
        check(!jam, "R6 jam released", int'(jam), 0);
        bp_req = 0;

        // R4: sixteen collisions then abort.
        do_reset();
        tx_req = 1;
        ncol = 0; ab = 0;
        while (!ab && ncol < 20) begin
            wait_grant(1000, n);
            if (n < 0) break;
            collide(10, jl, ab, dr);
            ncol++;
        end
        check(ab, "R4 abort seen", int'(ab), 1);
        check(ncol == 16, "R4 attempts", ncol, 16);
        tx_req = 0;

        // R7, R8, R9: partition after more than 64 collisions.
        do_reset();
        part_en = 1;
        tx_req = 1;
        for (int c = 1; c <= 65; c++) begin
            wait_grant(1000, n);
            if (n < 0) break;
            collide(10, jl, ab, dr);
            if (c == 64) check(rx_en, "R7 open at 64", int'(rx_en), 1);
            if (ab) begin
                tx_req = 0; @(negedge clk); tx_req = 1;
            end
        end
        check(!rx_en, "R7 closed at 65", int'(rx_en), 0);
        part_en = 0;
        @(negedge clk);
        check(rx_en, "R9 disabled partition", int'(rx_en), 1);
        part_en = 1;
        @(negedge clk);
        check(!rx_en, "R7 re-enabled", int'(rx_en), 0);
        wait_grant(1000, n);
        check(n >= 0, "R8 grant while partitioned", n, 0);
        repeat (300) @(negedge clk);
        check(!rx_en, "R8 still closed before slot", int'(rx_en), 0);
        repeat (300) @(negedge clk);
        check(rx_en, "R8 released after clean slot", int'(rx_en), 1);
        tx_end = 1; @(negedge clk); tx_end = 0; tx_req = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule